// File: doc/BRIEF.md
# USB Receive Line Framer

This block sits behind a clock-recovery stage that presents one classified line state per bit time, near the middle of the bit. It recovers the packet framing from that symbol stream. It detects the start of a packet and undoes the NRZI line coding. It removes the zeros that the sender inserted after long runs of ones. It reports a run of ones that is too long as a stuffing error. It also recognises the single-ended-zero sequence that ends a packet.

Symbols arrive on `line_i` together with the strobe `sym_valid_i`. Every output is a registered single-cycle pulse that appears in the clock cycle after the strobe that caused it. Byte assembly, packet-ID checks, CRC and transmission are handled by the blocks around it.

Top module: `usb_rx_framer`

## Requirements
- R1: `line_i` codes are J=2'b10, K=2'b01, SE0=2'b00, SE1=2'b11. After reset all outputs are low, the framer is idle, and the previous-symbol register holds J.
- R2: In idle, a K strobe whose previous symbol is J raises `sop_o` for one cycle after that strobe, and the K yields no data bit. A K that follows any other symbol starts nothing.
- R3: While receiving, a J or K equal to the previous J/K symbol decodes to 1, and a changed one decodes to 0. The bit appears on `bit_o` with `bit_valid_o` one cycle after the strobe, and never together with any other pulse.
- R4: A counter of consecutive decoded ones is cleared at SOP and on every decoded zero. When it holds 6, the next J/K is the stuff slot: a 0 there is dropped with no output and the counter clears.
- R5: A 1 in the stuff slot pulses `stuff_err_o`, and every later J/K is discarded until the packet ends.
- R6: An SE0 strobe while receiving starts end-of-packet handling and produces no data bit.
- R7: An SE1 strobe while receiving produces no data bit and leaves the previous symbol and the ones counter unchanged.
- R8: In end-of-packet handling, a J strobe pulses `eop_o` and returns to idle with J as the previous symbol. That J yields no data bit.
- R9: If the fourth non-J strobe counted from the opening SE0 (that SE0 included) arrives with no J in between, `eop_tmo_o` pulses instead of `eop_o` and the block returns to idle.
- R10: An SE0 that lands in the stuff slot starts end-of-packet handling and raises no stuffing error.
- R11: Cycles with `sym_valid_i` low change no state and raise no output, whatever `line_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Strobe: `line_i` holds the mid-bit symbol |
| line_i | input | 2 | Line symbol code (J, K, SE0, SE1) |
| bit_o | output | 1 | Decoded data bit |
| bit_valid_o | output | 1 | `bit_o` is valid this cycle |
| sop_o | output | 1 | Start-of-packet pulse |
| eop_o | output | 1 | End-of-packet pulse |
| stuff_err_o | output | 1 | Bit-stuffing violation pulse |
| eop_tmo_o | output | 1 | End-of-packet timeout pulse |

## Verification
Two functions can want the same strobe: the stuff-slot handling and the start of end-of-packet handling. This happens when SE0 arrives exactly as the ones counter reaches six. The bench drives six ones and then SE0, and expects neither an error nor a data bit. The following J must then close the packet with `eop_o`. A second run puts a K in the same slot so that the error path is judged against it.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DATA = 2'b01,
    ST_EOP  = 2'b10
  } rx_state_e;
endpackage

// File: rtl/usb_nrzi_track.sv
module usb_nrzi_track
  import usb_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      upd_i,
  input  line_sym_e sym_i,
  output line_sym_e prev_o,
  output logic      same_o
);
  line_sym_e prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= LS_J;
    else if (upd_i) prev_q <= sym_i;
  end

  assign prev_o = prev_q;
  assign same_o = (sym_i == prev_q);

  AST_PREV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(prev_q)); // R7
endmodule

// File: rtl/usb_stuff_count.sv
module usb_stuff_count #(
  parameter int unsigned RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic one_i,
  output logic slot_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (one_i && cnt_q != RUN_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o = (cnt_q == RUN_MAX);

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RUN_MAX); // R4
  AST_SLOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !slot_o); // R4
endmodule

// File: rtl/usb_eop_timer.sv
module usb_eop_timer #(
  parameter int unsigned TMO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned TW = $clog2(TMO + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO - 1);

  logic [TW-1:0] cnt_q;

  // opening SE0 counts as the first non-J symbol
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i)               cnt_q <= TW'(1);
    else if (tick_i && !expire_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i && (cnt_q >= LAST);

  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R9
endmodule

// File: rtl/usb_rx_framer.sv
module usb_rx_framer
  import usb_rx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 6,
  parameter int unsigned EOP_TMO   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_valid_i,
  input  logic [1:0] line_i,
  output logic       bit_o,
  output logic       bit_valid_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       stuff_err_o,
  output logic       eop_tmo_o
);
  line_sym_e sym;
  line_sym_e prev;
  rx_state_e state_q, state_d;
  logic      discard_q, discard_d;
  logic      is_j, is_k, is_se0, is_se1;
  logic      same, slot, expire;
  logic      prev_upd, cnt_clr, cnt_one, tmr_start, tmr_tick;
  logic      bit_d, bit_valid_d, sop_d, eop_d, err_d, tmo_d;

  assign sym    = line_sym_e'(line_i);
  assign is_j   = (sym == LS_J);
  assign is_k   = (sym == LS_K);
  assign is_se0 = (sym == LS_SE0);
  assign is_se1 = (sym == LS_SE1);

  // SE1 while receiving leaves the NRZI reference untouched
  assign prev_upd = sym_valid_i && !(state_q == ST_DATA && is_se1);
  assign tmr_tick = sym_valid_i && (state_q == ST_EOP) && !is_j;

  usb_nrzi_track u_nrzi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (prev_upd),
    .sym_i  (sym),
    .prev_o (prev),
    .same_o (same)
  );

  usb_stuff_count #(.RUN_LEN(STUFF_RUN)) u_stuff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .one_i  (cnt_one),
    .slot_o (slot)
  );

  usb_eop_timer #(.TMO(EOP_TMO)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .tick_i   (tmr_tick),
    .expire_o (expire)
  );

  always_comb begin
    state_d     = state_q;
    discard_d   = discard_q;
    cnt_clr     = 1'b0;
    cnt_one     = 1'b0;
    tmr_start   = 1'b0;
    bit_d       = 1'b0;
    bit_valid_d = 1'b0;
    sop_d       = 1'b0;
    eop_d       = 1'b0;
    err_d       = 1'b0;
    tmo_d       = 1'b0;
    if (sym_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_k && prev == LS_J) begin
            sop_d     = 1'b1;
            state_d   = ST_DATA;
            discard_d = 1'b0;
            cnt_clr   = 1'b1;
          end
        end
        ST_DATA: begin
          if (is_se0) begin
            state_d   = ST_EOP;
            tmr_start = 1'b1;
          end else if ((is_j || is_k) && !discard_q) begin
            if (slot) begin
              if (same) begin
                err_d     = 1'b1;
                discard_d = 1'b1;
              end else begin
                cnt_clr = 1'b1;
              end
            end else begin
              bit_valid_d = 1'b1;
              bit_d       = same;
              cnt_one     = same;
              cnt_clr     = !same;
            end
          end
        end
        ST_EOP: begin
          if (is_j) begin
            eop_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (expire) begin
            tmo_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      discard_q   <= 1'b0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      sop_o       <= 1'b0;
      eop_o       <= 1'b0;
      stuff_err_o <= 1'b0;
      eop_tmo_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      discard_q   <= discard_d;
      bit_o       <= bit_d;
      bit_valid_o <= bit_valid_d;
      sop_o       <= sop_d;
      eop_o       <= eop_d;
      stuff_err_o <= err_d;
      eop_tmo_o   <= tmo_d;
    end
  end

  AST_BIT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> !(sop_o || eop_o || stuff_err_o || eop_tmo_o)); // R3
  AST_SOP_ENTERS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> state_q == ST_DATA); // R2
  AST_EOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> state_q == ST_IDLE); // R8
  AST_SE0_NO_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && line_i == LS_SE0) |=> !bit_valid_o); // R6
  AST_SE1_NO_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && line_i == LS_SE1) |=> !bit_valid_o); // R7
  AST_ERR_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> !bit_valid_o && state_q == ST_DATA); // R5
  AST_TMO_NOT_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_tmo_o |-> !eop_o && state_q == ST_IDLE); // R9
  AST_NO_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> !(bit_valid_o || sop_o || eop_o || stuff_err_o || eop_tmo_o)); // R11
endmodule

// File: tb/usb_rx_framer_tb_top.sv
module usb_rx_framer_tb_top;
  localparam logic [1:0] J = 2'b10, K = 2'b01, S0 = 2'b00, S1 = 2'b11;
  localparam int NV = 50;
  // {sym, valid, bit, sop, eop, err, tmo}
  localparam logic [7:0] VEC [0:NV-1] = '{
    {J,6'b000000},                                   // idle J, no SOP (R2)
    {K,6'b001000},                                   // SOP (R2)
    {K,6'b110000}, {J,6'b100000},                    // NRZI 1,0 (R3)
    {J,6'b110000}, {J,6'b110000}, {J,6'b110000},
    {J,6'b110000}, {J,6'b110000}, {J,6'b110000},     // six ones
    {K,6'b000000},                                   // stuff zero dropped (R4)
    {K,6'b110000}, {J,6'b100000},
    {S1,6'b000000},                                  // SE1 ignored (R7)
    {J,6'b110000},                                   // prev still J (R7)
    {S0,6'b000000}, {S0,6'b000000},                  // SE0 no bit (R6)
    {J,6'b000100},                                   // EOP (R8)
    {K,6'b001000},
    {K,6'b110000}, {K,6'b110000}, {K,6'b110000},
    {K,6'b110000}, {K,6'b110000}, {K,6'b110000},
    {K,6'b000010},                                   // stuff error (R5)
    {J,6'b000000}, {K,6'b000000},                    // discarded (R5)
    {S0,6'b000000}, {J,6'b000100},
    {K,6'b001000},
    {K,6'b110000}, {K,6'b110000}, {K,6'b110000},
    {K,6'b110000}, {K,6'b110000}, {K,6'b110000},
    {S0,6'b000000},                                  // SE0 in stuff slot (R10)
    {J,6'b000100},                                   // closes normally (R10)
    {K,6'b001000}, {J,6'b100000},
    {S0,6'b000000}, {S0,6'b000000}, {K,6'b000000},
    {S0,6'b000001},                                  // EOP timeout (R9)
    {K,6'b000000}, {J,6'b000000},                    // SE0->K no SOP (R2)
    {K,6'b001000}, {S0,6'b000000}, {J,6'b000100}
  };

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [1:0] line = J;
  logic bit_q, bv, sop, eop, err, tmo;
  int errs = 0, checks = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  usb_rx_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(vld), .line_i(line),
    .bit_o(bit_q), .bit_valid_o(bv), .sop_o(sop), .eop_o(eop),
    .stuff_err_o(err), .eop_tmo_o(tmo)
  );

  function automatic logic [5:0] outs();
    return {bv, bit_q, sop, eop, err, tmo};
  endfunction

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // one strobe, outputs sampled in the following cycle
  task automatic strobe(input logic [1:0] s, input logic [5:0] exp, input string tag);
    @(negedge clk); line = s; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    chk(tag, outs(), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", outs(), 6'b0);
    rst_n = 1'b1;
    // R1: prev resets to J, so the first K is SOP
    strobe(K, 6'b001000, "R1 first K after reset");
    strobe(S0, 6'b000000, "R6 SE0");
    strobe(J, 6'b000100, "R8 EOP");
    for (int i = 0; i < NV; i++)
      strobe(VEC[i][7:6], VEC[i][5:0], $sformatf("R3 table step %0d", i));
    // R11: unstrobed line activity is ignored
    strobe(K, 6'b001000, "R2 SOP");
    strobe(K, 6'b110000, "R3 one");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); line = (i % 2 == 0) ? J : S0;
      chk("R11 no strobe quiet", outs(), 6'b0);
    end
    strobe(K, 6'b110000, "R11 prev kept through gaps");
    strobe(S0, 6'b000000, "R6 SE0");
    strobe(J, 6'b000100, "R8 EOP");
    // R1: reset mid-packet returns to idle with prev J
    strobe(K, 6'b001000, "R2 SOP");
    strobe(J, 6'b100000, "R3 zero");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 outputs in reset", outs(), 6'b0);
    rst_n = 1'b1;
    strobe(J, 6'b000000, "R1 idle after reset");
    strobe(K, 6'b001000, "R1 SOP after reset");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule